// File: doc/BRIEF.md
# Level-Line Interrupt Gateway with Deferred Re-arm

This block keeps the per-source bookkeeping that sits between a bank of level-sensitive interrupt lines and a priority arbiter. Every source carries three state bits: a visible request bit that the arbiter sees, an ownership bit that is set while a target is servicing the source, and a shadow bit. The shadow bit remembers a new assertion that arrived while the source was owned.

Line activity is taken as events: a rising line is a new request and a falling line withdraws a shadowed one. A target takes a source with a one-cycle take strobe carrying the source ID. It hands the source back with a one-cycle release strobe carrying the ID. On release, a request that was shadowed during service comes back as visible, so no assertion made during service is lost. The visible bits leave the block packed into 32-bit words for the arbiter. Source ID 0 means "nothing" and never holds state.

Top module: `irq_gateway`

## Requirements
- R1: Source n appears at `pend_o[n]`, which is word n/32, bit n%32 of the packed output. Output bits at index NUM_SRC and above always read 0.
- R2: A rising edge on line n (n ≥ 1) of a source that is not owned sets its visible bit. The bit is visible after the first clock edge at which the line is sampled high.
- R3: A rising edge on line n of an owned source sets only its shadow bit. The visible bit keeps its value.
- R4: A falling edge on line n clears its shadow bit and leaves the visible bit unchanged. A later release therefore does not re-raise the request.
- R5: A take strobe for ID n clears the visible bit of n and marks n as owned. The change shows one clock edge later.
- R6: A release strobe for an ID that is not owned has no effect.
- R7: A release strobe for an owned ID clears ownership. If the shadow bit of n is set at that point, the visible bit is set again. The shadow bit is not cleared by a release. With no shadow bit, the visible bit stays 0.
- R8: When strobes and a line edge hit the same source in one cycle, the order is fixed: release first, then take, then the line edge, which is judged on the ownership that results.
- R9: ID 0, and any ID of NUM_SRC or above, is ignored by both strobes. Line 0 never sets any bit.
- R10: Reset (synchronous, active high) clears every visible, shadow and ownership bit. It also clears the line history, so a line that is high when reset ends counts as a rising edge on the first clock edge after reset.
- R11: A line held high with no new edge does not set the visible bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_level_i | input | NUM_SRC | Level of each interrupt line |
| take_vld_i | input | 1 | One-cycle take strobe |
| take_id_i | input | ID_W | Source ID being taken |
| rel_vld_i | input | 1 | One-cycle release strobe |
| rel_id_i | input | ID_W | Source ID being released |
| pend_o | output | NUM_WORDS*32 | Packed visible request bits |

## Verification
A wrong ownership bit shows up one edge after the next rising line of that source. The visible bit either rises when it should stay low or stays low when it should rise. A lost or stale shadow bit stays hidden until the matching release, and then shows up on the next edge as a missing or extra replay. The sequences therefore pair every take with a release, and place line edges and strobes in the same cycle, so that each hidden bit is brought out on `pend_o` within one or two cycles.

// File: rtl/gw_pkg.sv
package gw_pkg;

    localparam int unsigned WORD_W = 32;

    function automatic int unsigned words_for(input int unsigned n_src);
        return (n_src + WORD_W - 1) / WORD_W;
    endfunction

    // Per-source state kept by the gateway
    typedef struct packed {
        logic pend;   // visible request
        logic hid;    // shadowed request seen while owned
        logic clm;    // owned by a target
    } src_state_t;

    // Events derived from one interrupt line
    typedef struct packed {
        logic rise;
        logic fall;
    } line_evt_t;

    // Strobe hits decoded for one source
    typedef struct packed {
        logic take;
        logic rel;
    } strobe_hit_t;

    // Next-state rule: release, then take, then line edge
    function automatic src_state_t src_next(input src_state_t cur,
                                            input strobe_hit_t hit,
                                            input line_evt_t evt);
        src_state_t nxt;
        nxt = cur;
        if (hit.rel && cur.clm) begin
            nxt.clm = 1'b0;
            if (cur.hid) nxt.pend = 1'b1;
        end
        if (hit.take) begin
            nxt.pend = 1'b0;
            nxt.clm  = 1'b1;
        end
        if (evt.rise) begin
            if (nxt.clm) nxt.hid  = 1'b1;
            else         nxt.pend = 1'b1;
        end
        if (evt.fall) nxt.hid = 1'b0;
        return nxt;
    endfunction

endpackage

// File: rtl/gw_line_edge.sv
module gw_line_edge
    import gw_pkg::*;
#(
    parameter int unsigned N = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      level_i,
    output line_evt_t [N-1:0] evt_o
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level_i;
    end

    for (genvar i = 0; i < N; i++) begin : g_evt
        assign evt_o[i].rise = level_i[i] & ~prev_q[i];
        assign evt_o[i].fall = ~level_i[i] & prev_q[i];
    end

endmodule

// File: rtl/gw_id_decode.sv
module gw_id_decode #(
    parameter int unsigned N    = 48,
    parameter int unsigned ID_W = 6
) (
    input  logic            vld_i,
    input  logic [ID_W-1:0] id_i,
    output logic [N-1:0]    hit_o
);

    // ID 0 is reserved; IDs at or above N match no output
    assign hit_o[0] = 1'b0;
    for (genvar i = 1; i < N; i++) begin : g_hit
        assign hit_o[i] = vld_i && (id_i == ID_W'(i));
    end

endmodule

// File: rtl/gw_src_cell.sv
module gw_src_cell
    import gw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  strobe_hit_t hit_i,
    input  line_evt_t   evt_i,
    output src_state_t  state_o
);

    src_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= src_next(state_q, hit_i, evt_i);
    end

    assign state_o = state_q;

    // R5: a take leaves the source owned and not visible
    p_take_clears_r5: assert property (@(posedge clk) disable iff (rst)
        hit_i.take && !evt_i.rise |=> state_q.clm && !state_q.pend);

    // R3: rise while owned only shadows the request
    p_shadow_only_r3: assert property (@(posedge clk) disable iff (rst)
        evt_i.rise && state_q.clm && !hit_i.rel && !hit_i.take
        |=> state_q.hid && $stable(state_q.pend));

    // R6: release of an unowned source changes nothing
    p_rel_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        hit_i.rel && !state_q.clm && !hit_i.take && !evt_i.rise && !evt_i.fall
        |=> $stable(state_q));

    // R7: release with a shadowed request replays it
    p_replay_r7: assert property (@(posedge clk) disable iff (rst)
        hit_i.rel && state_q.clm && state_q.hid && !hit_i.take
        |=> state_q.pend && !state_q.clm);

    // R4: a falling line drops the shadow bit
    p_fall_clears_r4: assert property (@(posedge clk) disable iff (rst)
        evt_i.fall |=> !state_q.hid);

endmodule

// File: rtl/irq_gateway.sv
module irq_gateway
    import gw_pkg::*;
#(
    parameter int unsigned NUM_SRC = 48,
    parameter int unsigned ID_W    = $clog2(NUM_SRC),
    localparam int unsigned NUM_WORDS = words_for(NUM_SRC),
    localparam int unsigned OUT_W     = NUM_WORDS * WORD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_level_i,
    input  logic               take_vld_i,
    input  logic [ID_W-1:0]    take_id_i,
    input  logic               rel_vld_i,
    input  logic [ID_W-1:0]    rel_id_i,
    output logic [OUT_W-1:0]   pend_o
);

    line_evt_t  [NUM_SRC-1:0] evt;
    logic       [NUM_SRC-1:0] take_hit;
    logic       [NUM_SRC-1:0] rel_hit;
    src_state_t [NUM_SRC-1:0] state;

    gw_line_edge #(.N(NUM_SRC)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (irq_level_i),
        .evt_o   (evt)
    );

    gw_id_decode #(.N(NUM_SRC), .ID_W(ID_W)) u_take_dec (
        .vld_i (take_vld_i),
        .id_i  (take_id_i),
        .hit_o (take_hit)
    );

    gw_id_decode #(.N(NUM_SRC), .ID_W(ID_W)) u_rel_dec (
        .vld_i (rel_vld_i),
        .id_i  (rel_id_i),
        .hit_o (rel_hit)
    );

    // Source 0 is reserved and holds no state
    assign state[0] = '0;
    logic unused_src0;
    assign unused_src0 = ^{evt[0], take_hit[0], rel_hit[0]};

    for (genvar i = 1; i < NUM_SRC; i++) begin : g_src
        strobe_hit_t hit;
        assign hit.take = take_hit[i];
        assign hit.rel  = rel_hit[i];
        gw_src_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .hit_i   (hit),
            .evt_i   (evt[i]),
            .state_o (state[i])
        );
    end

    // Pack visible bits into words; padding reads zero
    for (genvar b = 0; b < OUT_W; b++) begin : g_pack
        if (b < NUM_SRC) begin : g_live
            assign pend_o[b] = state[b].pend;
        end else begin : g_pad
            assign pend_o[b] = 1'b0;
        end
    end

    // R9: the reserved line never raises anything
    p_line0_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        irq_level_i[0] |=> !pend_o[0]);

    // R2: rising line on an unowned source shows on the next edge
    p_rise_visible_r2: assert property (@(posedge clk) disable iff (rst)
        evt[1].rise && !state[1].clm && !take_hit[1] |=> pend_o[1]);

endmodule

// File: tb/test_irq_gateway.sv
`timescale 1ns/1ps
module test_irq_gateway;

    localparam int unsigned NSRC = 48;
    localparam int unsigned IDW  = 6;
    localparam int unsigned OW   = 64;

    typedef struct packed {
        logic       lv_en;
        logic [5:0] lv_id;
        logic       lv_val;
        logic       tk_en;
        logic [5:0] tk_id;
        logic       rl_en;
        logic [5:0] rl_id;
        logic [5:0] ck_id;
        logic       ck_val;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 6'd5,  1'b1, 1'b0, 6'd0,  1'b0, 6'd0,  6'd5,  1'b1, 4'd2},  // R2 rise sets
        '{1'b0, 6'd0,  1'b0, 1'b0, 6'd0,  1'b0, 6'd0,  6'd5,  1'b1, 4'd11}, // R11 steady high
        '{1'b0, 6'd0,  1'b0, 1'b1, 6'd5,  1'b0, 6'd0,  6'd5,  1'b0, 4'd5},  // R5 take
        '{1'b1, 6'd5,  1'b0, 1'b0, 6'd0,  1'b0, 6'd0,  6'd5,  1'b0, 4'd4},  // R4 fall
        '{1'b1, 6'd5,  1'b1, 1'b0, 6'd0,  1'b0, 6'd0,  6'd5,  1'b0, 4'd3},  // R3 shadow only
        '{1'b0, 6'd0,  1'b0, 1'b0, 6'd0,  1'b1, 6'd5,  6'd5,  1'b1, 4'd7},  // R7 replay
        '{1'b0, 6'd0,  1'b0, 1'b0, 6'd0,  1'b1, 6'd5,  6'd5,  1'b1, 4'd6},  // R6 unowned release
        '{1'b0, 6'd0,  1'b0, 1'b1, 6'd5,  1'b0, 6'd0,  6'd5,  1'b0, 4'd5},  // R5 take again
        '{1'b1, 6'd5,  1'b0, 1'b0, 6'd0,  1'b0, 6'd0,  6'd5,  1'b0, 4'd4},  // R4 fall drops shadow
        '{1'b0, 6'd0,  1'b0, 1'b0, 6'd0,  1'b1, 6'd5,  6'd5,  1'b0, 4'd4},  // R4 no replay
        '{1'b1, 6'd33, 1'b1, 1'b0, 6'd0,  1'b0, 6'd0,  6'd33, 1'b1, 4'd1},  // R1 second word
        '{1'b0, 6'd0,  1'b0, 1'b1, 6'd33, 1'b0, 6'd0,  6'd33, 1'b0, 4'd5},  // R5 take 33
        '{1'b1, 6'd5,  1'b1, 1'b1, 6'd5,  1'b0, 6'd0,  6'd5,  1'b0, 4'd8},  // R8 take then rise
        '{1'b1, 6'd5,  1'b0, 1'b0, 6'd0,  1'b1, 6'd5,  6'd5,  1'b1, 4'd8},  // R8 release then fall
        '{1'b0, 6'd0,  1'b0, 1'b1, 6'd5,  1'b0, 6'd0,  6'd5,  1'b0, 4'd5},  // R5
        '{1'b1, 6'd5,  1'b1, 1'b0, 6'd0,  1'b1, 6'd5,  6'd5,  1'b1, 4'd8},  // R8 release then rise
        '{1'b1, 6'd0,  1'b1, 1'b1, 6'd0,  1'b0, 6'd0,  6'd0,  1'b0, 4'd9},  // R9 id 0
        '{1'b0, 6'd0,  1'b0, 1'b1, 6'd50, 1'b0, 6'd0,  6'd5,  1'b1, 4'd9},  // R9 take out of range
        '{1'b0, 6'd0,  1'b0, 1'b0, 6'd0,  1'b1, 6'd50, 6'd5,  1'b1, 4'd9},  // R9 release out of range
        '{1'b0, 6'd0,  1'b0, 1'b0, 6'd0,  1'b1, 6'd33, 6'd33, 1'b0, 4'd7}   // R7 release, no shadow
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] lv = '0;
    logic            tk_vld = 1'b0;
    logic [IDW-1:0]  tk_id = '0;
    logic            rl_vld = 1'b0;
    logic [IDW-1:0]  rl_id = '0;
    logic [OW-1:0]   pend;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    irq_gateway #(.NUM_SRC(NSRC), .ID_W(IDW)) i_irq_gateway (
        .clk         (clk),
        .rst         (rst),
        .irq_level_i (lv),
        .take_vld_i  (tk_vld),
        .take_id_i   (tk_id),
        .rel_vld_i   (rl_vld),
        .rel_id_i    (rl_id),
        .pend_o      (pend)
    );

    task automatic check_vec(input string tag, input logic [OW-1:0] exp);
        total++;
        if (pend !== exp) begin
            bad++;
            $display("FAIL %s: pend=%h expected %h", tag, pend, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        @(negedge clk);
        if (v.lv_en) lv[v.lv_id] = v.lv_val;
        tk_vld = v.tk_en;  tk_id = v.tk_id;
        rl_vld = v.rl_en;  rl_id = v.rl_id;
        @(posedge clk);
        #1;
        total++;
        if (pend[v.ck_id] !== v.ck_val) begin
            bad++;
            $display("FAIL R%0d step %0d: pend[%0d]=%0b expected %0b",
                     v.req, idx, v.ck_id, pend[v.ck_id], v.ck_val);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        tk_vld = 1'b0;
        rl_vld = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_vec("R10 reset state", '0);
        @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) run_vec(TBL[k], k);
        idle();

        // R1: full word layout, padding bits 48..63 stay zero
        @(negedge clk);
        lv[40] = 1'b1;
        @(posedge clk);
        #1;
        check_vec("R1 packed layout", (64'd1 << 5) | (64'd1 << 40));

        // Take 40 so it is owned going into reset
        @(negedge clk);
        tk_vld = 1'b1; tk_id = 6'd40;
        @(posedge clk);
        #1;
        check_vec("R5 take 40", 64'd1 << 5);
        idle();

        // R10: reset clears everything, lines high at release act as rises
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check_vec("R10 during reset", '0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check_vec("R10 after release", {16'b0, lv} & ~64'd1);

        // R11: lines held high set nothing new after a take
        @(negedge clk);
        tk_vld = 1'b1; tk_id = 6'd40;
        @(posedge clk);
        #1;
        idle();
        @(posedge clk);
        #1;
        check_vec("R11 held lines", ({16'b0, lv} & ~64'd1) & ~(64'd1 << 40));

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule